// File: doc/BRIEF.md
# Serial Modulator Channel Input Front-End

This block is the capture stage in front of a bank of sigma-delta decimation filters. It serves `NUM_CH` one-bit serial input channels. Each channel receives a serial clock and a serial data line, which arrive asynchronously to the system clock. For every active edge of its chosen serial clock, a channel delivers one captured data bit together with a valid strobe that lasts one system clock. The strobe is synchronous to the system clock.

Each channel has its own settings:

- **Input select.** The channel reads either its own pin pair or the pin pair of the next-higher channel. The top channel wraps round to channel 0.
- **Sampling edge.** The channel samples on either the rising or the falling edge of its serial clock.
- **Clock source.** The channel's serial clock is either the external pin clock or an internally derived clock.

Two adjacent channels can therefore share one stereo PDM microphone. The upper channel samples its own pins on the rising edge and carries the left audio. The lower channel reads the same pins on the falling edge and carries the right audio.

All pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized clock level with its value one system clock earlier. The settings of a channel are latched only while that channel is disabled. This means that a reconfiguration can never split a sample.

Top module: `sdm_chan_frontend`

## Requirements
- R1: With `cfg_in_sel[i]`=0, channel i takes clock and data from `pin_sclk[i]`/`pin_sdat[i]`. With `cfg_in_sel[i]`=1, it takes them from pin index (i+1) mod `NUM_CH`.
- R2: Bit 0 of the 2-bit field `cfg_edge[2i+1:2i]` picks the sampling edge: 0 selects the rising edge and 1 selects the falling edge. Bit 1 has no effect, so value 2 behaves as 0 and value 3 behaves as 1.
- R3: When two channels share one pin pair and sample on opposite edges, the rising-edge channel captures the data present at the rising edge. The falling-edge channel captures the data present at the falling edge.
- R4: A 2-bit field `cfg_clk_src[2i+1:2i]` equal to 0 selects the selected pin clock. Any non-zero value selects `int_sclk`, and the pin clock is then ignored. In both cases the data comes from the selected data pin.
- R5: Each sampling edge of the selected clock produces a `smp_valid[i]` pulse exactly one system clock long. The captured bit appears on `smp_bit[i]` and holds until the next pulse. This assumes each serial clock level lasts at least two system clocks.
- R6: After reset, all `smp_valid` and `smp_bit` outputs are 0.
- R7: While `ch_en[i]` is 0, `smp_valid[i]` stays 0 and `smp_bit[i]` is 0, whatever the pins do.
- R8: Channel settings are latched only while `ch_en[i]` is 0. A change made while the channel is enabled has no effect until the channel is disabled and re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel enable |
| cfg_in_sel | input | NUM_CH | Per-channel pin-pair select (0 own, 1 next-higher) |
| cfg_edge | input | 2*NUM_CH | Per-channel sampling edge field |
| cfg_clk_src | input | 2*NUM_CH | Per-channel clock source field |
| pin_sclk | input | NUM_CH | Asynchronous serial clock pins |
| pin_sdat | input | NUM_CH | Asynchronous serial data pins |
| int_sclk | input | 1 | Internally derived serial clock |
| smp_valid | output | NUM_CH | One-cycle sample strobe per channel |
| smp_bit | output | NUM_CH | Captured serial bit per channel |

## Verification
The bench builds the block with `NUM_CH`=4 rather than the default of 2. This provides a top channel whose redirection wraps to channel 0, and spare channels that can stay disabled while neighbours run. It also lets one channel use the internal clock while another uses its pin clock. A stereo pair on channels 0 and 1 is driven through a table of select, edge and data combinations. Each table entry gives distinct left and right bits, so choosing the wrong edge or the wrong pin pair produces a visibly wrong bit.

// File: rtl/sdm_fe_pkg.sv
package sdm_fe_pkg;
  // Latched per-channel setting
  typedef struct packed {
    logic in_sel;    // 1: read next-higher channel pins
    logic fall_edge; // 1: sample on falling edge
    logic int_clk;   // 1: use internal serial clock
  } chan_cfg_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sdm_sync_bank.sv
module sdm_sync_bank #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sdm_chan_route.sv
module sdm_chan_route
  import sdm_fe_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  chan_cfg_t [NUM_CH-1:0] cfg,
  input  logic [NUM_CH-1:0]      pin_clk_s,
  input  logic [NUM_CH-1:0]      pin_dat_s,
  input  logic                   int_clk_s,
  output logic [NUM_CH-1:0]      sel_clk,
  output logic [NUM_CH-1:0]      sel_dat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_route
    localparam int unsigned NXT = (i + 1) % NUM_CH;
    logic pclk;
    assign pclk       = cfg[i].in_sel ? pin_clk_s[NXT] : pin_clk_s[i];
    assign sel_dat[i] = cfg[i].in_sel ? pin_dat_s[NXT] : pin_dat_s[i];
    assign sel_clk[i] = cfg[i].int_clk ? int_clk_s : pclk;
  end
endmodule

// File: rtl/sdm_edge_capture.sv
module sdm_edge_capture (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fall_mode,
  input  logic sclk_lvl,
  input  logic sdat_lvl,
  output logic valid_o,
  output logic bit_o
);
  logic prev_q;
  logic hit;

  assign hit = fall_mode ? (prev_q & ~sclk_lvl) : (~prev_q & sclk_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      prev_q <= sclk_lvl;
      if (!en) begin
        valid_o <= 1'b0;
        bit_o   <= 1'b0;
      end else if (hit) begin
        valid_o <= 1'b1;
        bit_o   <= sdat_lvl;
      end else begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdm_chan_frontend.sv
module sdm_chan_frontend
  import sdm_fe_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     ch_en,
  input  logic [NUM_CH-1:0]     cfg_in_sel,
  input  logic [2*NUM_CH-1:0]   cfg_edge,
  input  logic [2*NUM_CH-1:0]   cfg_clk_src,
  input  logic [NUM_CH-1:0]     pin_sclk,
  input  logic [NUM_CH-1:0]     pin_sdat,
  input  logic                  int_sclk,
  output logic [NUM_CH-1:0]     smp_valid,
  output logic [NUM_CH-1:0]     smp_bit
);
  localparam int unsigned SYNC_W = 2 * NUM_CH + 1;

  chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic [SYNC_W-1:0]      sync_out;
  logic [NUM_CH-1:0]      clk_s, dat_s, sel_clk, sel_dat;
  logic                   int_s;

  // Settings load only while a channel is idle
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (!ch_en[i]) begin
          cfg_q[i].in_sel    <= cfg_in_sel[i];
          cfg_q[i].fall_edge <= cfg_edge[2*i];
          cfg_q[i].int_clk   <= |cfg_clk_src[2*i +: 2];
        end
      end
    end
  end

  sdm_sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .d_async({int_sclk, pin_sdat, pin_sclk}),
    .d_sync(sync_out)
  );

  assign clk_s = sync_out[NUM_CH-1:0];
  assign dat_s = sync_out[2*NUM_CH-1:NUM_CH];
  assign int_s = sync_out[SYNC_W-1];

  sdm_chan_route #(.NUM_CH(NUM_CH)) route_i (
    .cfg(cfg_q), .pin_clk_s(clk_s), .pin_dat_s(dat_s), .int_clk_s(int_s),
    .sel_clk(sel_clk), .sel_dat(sel_dat)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cap
    sdm_edge_capture cap_i (
      .clk(clk), .rst(rst), .en(ch_en[i]),
      .fall_mode(cfg_q[i].fall_edge),
      .sclk_lvl(sel_clk[i]), .sdat_lvl(sel_dat[i]),
      .valid_o(smp_valid[i]), .bit_o(smp_bit[i])
    );
  end
endmodule

// File: rtl/sdm_chan_frontend_chk.sv
module sdm_chan_frontend_chk
  import sdm_fe_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_CH-1:0]      ch_en,
  input logic [NUM_CH-1:0]      smp_valid,
  input logic [NUM_CH-1:0]      smp_bit,
  input chan_cfg_t [NUM_CH-1:0] cfg_q
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R7: disabled channel stays silent and cleared
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |=> (!smp_valid[i] && !smp_bit[i]));
    // R7: a strobe only follows an enabled cycle
    a_r7_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
      smp_valid[i] |-> $past(ch_en[i]));
    // R5: strobe lasts a single system clock
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      smp_valid[i] |=> !smp_valid[i]);
    // R5: captured bit holds between strobes
    a_r5_bit_holds: assert property (@(posedge clk) disable iff (rst)
      ($past(ch_en[i]) && !smp_valid[i]) |-> $stable(smp_bit[i]));
    // R8: latched settings frozen while enabled
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
      $past(ch_en[i]) |-> $stable(cfg_q[i]));
  end
endmodule

bind sdm_chan_frontend sdm_chan_frontend_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .ch_en(ch_en), .smp_valid(smp_valid),
  .smp_bit(smp_bit), .cfg_q(cfg_q)
);

// File: tb/sdm_chan_frontend_tb_top.sv
module sdm_chan_frontend_tb_top;
  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   ch_en = '0, cfg_in_sel = '0, pin_sclk = '0, pin_sdat = '0;
  logic [2*N-1:0] cfg_edge = '0, cfg_clk_src = '0;
  logic           int_sclk = 1'b0;
  logic [N-1:0]   smp_valid, smp_bit;

  int errors = 0, checks = 0;
  int cnt [N];
  logic last [N];
  int run_len [N], max_run [N];

  always #5 clk = ~clk;

  sdm_chan_frontend #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst(rst), .ch_en(ch_en), .cfg_in_sel(cfg_in_sel),
    .cfg_edge(cfg_edge), .cfg_clk_src(cfg_clk_src), .pin_sclk(pin_sclk),
    .pin_sdat(pin_sdat), .int_sclk(int_sclk), .smp_valid(smp_valid),
    .smp_bit(smp_bit)
  );

  // Monitor away from the active edge
  initial begin
    for (int c = 0; c < N; c++) begin cnt[c] = 0; last[c] = 0; run_len[c] = 0; max_run[c] = 0; end
  end
  always @(negedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (smp_valid[c]) begin
        cnt[c]++; last[c] = smp_bit[c]; run_len[c]++;
        if (run_len[c] > max_run[c]) max_run[c] = run_len[c];
      end else run_len[c] = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input int ch, input bit sel, input logic [1:0] edg, input logic [1:0] src);
    @(negedge clk); ch_en[ch] = 1'b0;
    wn(2);
    cfg_in_sel[ch] = sel; cfg_edge[2*ch +: 2] = edg; cfg_clk_src[2*ch +: 2] = src;
    wn(2);
    ch_en[ch] = 1'b1;
    wn(2);
  endtask

  // Pins 1 carry (dL,dR); pins 0 carry inverted data; both clocks in phase
  task automatic run_period(input bit dl, input bit dr);
    @(negedge clk); pin_sdat[1] = dl; pin_sdat[0] = ~dl;
    wn(4); pin_sclk[1:0] = 2'b11;
    wn(4); pin_sdat[1] = dr; pin_sdat[0] = ~dr;
    wn(4); pin_sclk[1:0] = 2'b00;
    wn(6);
  endtask

  task automatic toggle_pin(input int p, input bit d);
    @(negedge clk); pin_sdat[p] = d;
    wn(4); pin_sclk[p] = 1'b1;
    wn(4); pin_sclk[p] = 1'b0;
    wn(6);
  endtask

  // {sel0, edge0, edge1, dL, dR}
  localparam logic [4:0] VEC [8] = '{
    5'b00010, 5'b00101, 5'b01010, 5'b01101,
    5'b10010, 5'b10101, 5'b11001, 5'b11110
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wn(4);
    rst = 1'b0;
    wn(2);
    // R6: reset state
    check(smp_valid == '0, "R6 valid after reset", smp_valid, 0);
    check(smp_bit == '0, "R6 bit after reset", smp_bit, 0);

    // R1 R2 R3: table of stereo pair settings
    for (int v = 0; v < 8; v++) begin
      bit s0, e0, e1, dl, dr, exp0, exp1;
      int c0, c1;
      {s0, e0, e1, dl, dr} = VEC[v];
      configure(0, s0, {1'b0, e0}, 2'd0);
      configure(1, 1'b0, {1'b0, e1}, 2'd0);
      c0 = cnt[0]; c1 = cnt[1];
      run_period(dl, dr);
      exp0 = e0 ? (s0 ? dr : ~dr) : (s0 ? dl : ~dl);
      exp1 = e1 ? dr : dl;
      check(cnt[0] - c0 == 1, "R1 ch0 pulse count", cnt[0] - c0, 1);
      check(last[0] == exp0, "R1 R3 ch0 captured bit", last[0], exp0);
      check(cnt[1] - c1 == 1, "R2 ch1 pulse count", cnt[1] - c1, 1);
      check(last[1] == exp1, "R2 R3 ch1 captured bit", last[1], exp1);
    end

    // R2: edge field values 3 and 2 follow bit 0
    begin
      int c1;
      configure(1, 1'b0, 2'd3, 2'd0);
      c1 = cnt[1];
      run_period(1'b0, 1'b1);
      check(last[1] == 1'b1 && cnt[1] - c1 == 1, "R2 edge value 3 falls", last[1], 1);
      configure(1, 1'b0, 2'd2, 2'd0);
      run_period(1'b1, 1'b0);
      check(last[1] == 1'b1, "R2 edge value 2 rises", last[1], 1);
    end

    // R7: disabled channel ignores pin activity
    begin
      int c2;
      ch_en[2] = 1'b0;
      c2 = cnt[2];
      toggle_pin(2, 1'b1);
      check(cnt[2] == c2, "R7 no pulse while disabled", cnt[2] - c2, 0);
      check(smp_bit[2] == 1'b0, "R7 bit zero while disabled", smp_bit[2], 0);
    end

    // R8: edge change while enabled is ignored until re-enable
    begin
      configure(0, 1'b0, 2'd0, 2'd0);
      @(negedge clk); cfg_edge[1:0] = 2'd1;
      run_period(1'b0, 1'b1);   // pin0: 1 at rise, 0 at fall
      check(last[0] == 1'b1, "R8 old edge kept while enabled", last[0], 1);
      @(negedge clk); ch_en[0] = 1'b0; wn(2); ch_en[0] = 1'b1; wn(2);
      run_period(1'b0, 1'b1);
      check(last[0] == 1'b0, "R8 new edge after re-enable", last[0], 0);
    end

    // R4: internal clock, pin clock ignored, data from own pin
    begin
      int c3;
      configure(3, 1'b0, 2'd0, 2'd1);
      c3 = cnt[3];
      toggle_pin(3, 1'b1);
      check(cnt[3] == c3, "R4 pin clock ignored on internal source", cnt[3] - c3, 0);
      @(negedge clk); pin_sdat[3] = 1'b1;
      wn(4); int_sclk = 1'b1; wn(4); int_sclk = 1'b0; wn(6);
      check(cnt[3] - c3 == 1, "R4 internal clock pulse", cnt[3] - c3, 1);
      check(last[3] == 1'b1, "R4 data from pin on internal clock", last[3], 1);
      configure(3, 1'b0, 2'd1, 2'd2);
      @(negedge clk); pin_sdat[3] = 1'b0;
      wn(4); int_sclk = 1'b1; wn(4); int_sclk = 1'b0; wn(6);
      check(cnt[3] - c3 == 2 && last[3] == 1'b0, "R4 source value 2 internal", last[3], 0);
    end

    // R1: top channel redirect wraps to channel 0 pins
    begin
      int c3;
      configure(3, 1'b1, 2'd0, 2'd0);
      c3 = cnt[3];
      run_period(1'b0, 1'b0);   // pin0 data 1
      check(cnt[3] - c3 == 1, "R1 wrap pulse count", cnt[3] - c3, 1);
      check(last[3] == 1'b1, "R1 wrap reads channel 0 pins", last[3], 1);
    end

    // R5: every strobe was one cycle wide
    for (int c = 0; c < N; c++)
      check(max_run[c] <= 1, "R5 strobe width", max_run[c], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule